// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a single 16-bit timer channel built around a counter and four general registers. The counter advances once for every clock cycle in which the `cnt_tick` input is high. `cnt_tick` comes from a prescaler that sits outside the block. Each general register is set up on its own to work in one of two ways:

- as a compare register, watched continuously against the counter;
- as a capture register, which takes a snapshot of the counter on a chosen edge of its own external input.

Any one register can be picked to reset the counter to zero when it matches or captures, which gives a programmable counting period. An optional up/down mode makes the counter bounce between its extremes. Sticky status flags record matches, captures, overflow and underflow. Software reaches everything through a small 16-bit word-wide register bus.

The counter direction is a two-state machine with states DIR_UP and DIR_DOWN, and it has these transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| TURN_DOWN | DIR_UP | DIR_DOWN | A tick while at 0xFFFF, up/down mode on |
| TURN_UP | DIR_DOWN | DIR_UP | A tick while at 0x0000 |
| FORCE_UP | any | DIR_UP | Up/down mode off, or a counter clear |

Register map, selected by `bus_addr`:

| Address | Register |
|---|---|
| 0 | Counter |
| 1 | Control |
| 2 | Status |
| 4 + k | General register k |

Control word fields:

| Bits | Meaning |
|---|---|
| [0] | Up/down mode |
| [2:1] | Clear-source register index |
| [3] | Clear enable |
| [4+3k] | Capture mode for register k |
| [6+3k:5+3k] | Edge code for register k: 00 none, 01 rising, 10 falling, 11 both |

Status word fields:

| Bits | Meaning |
|---|---|
| [3:0] | Per-register match/capture flags |
| [4] | Overflow |
| [5] | Underflow |

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset the counter reads 0x0000, control reads 0x0000 (all registers in compare mode, no capture edge), status reads 0x0000 and every general register reads 0xFFFF.
- R2: With control bit 0 clear, each tick raises the counter by one. A tick at 0xFFFF wraps it to 0x0000 and sets status bit 4 (overflow).
- R3: With control bit 0 set, the counter counts up to 0xFFFF. The tick there moves it to 0xFFFE, starts down-counting and sets status bit 4. Counting down, the tick at 0x0000 moves it to 0x0001, resumes up-counting and sets status bit 5 (underflow).
- R4: A register in compare mode whose value equals the counter sets status bit k. A compare register that is not equal to the counter leaves its bit clear.
- R5: A register in capture mode (control bit 4+3k = 1) loads the counter value and sets status bit k on the edge of `cap_in[k]` chosen by its edge code (00 none, 01 rising, 10 falling, 11 both). The input passes two synchronizing flops, and the load happens on the third clock edge after the input change.
- R6: With control bit 3 set and bits [2:1] = k, two events clear the counter to 0x0000 and select up-counting. One is a tick while compare register k equals the counter, which clears instead of incrementing, so the period is GRk+1 ticks. The other is a capture into register k.
- R7: Status flags are sticky. A bus write of 0 to a flag bit clears it only if a status read has returned that bit as 1 since the last clear. A write of 1, or a write of 0 without such a read, leaves the flag unchanged.
- R8: When a flag's set event occurs in the same cycle as its clear, the flag stays set.
- R9: A bus write to the counter takes priority over counting and clearing in the same cycle.
- R10: Registers are accessed as whole 16-bit words. A write to the counter or to a general register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Prescaled count enable |
| cap_in | input | 4 | Asynchronous capture inputs, one per general register |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms status flags for clearing) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |

## Verification
The bench goes after the following corner cases:

- **Turn-around values in up/down mode.** A design that reflects at the wrong value would read 0xFFFF twice or fall to 0x0000 instead of 0xFFFE and 0x0001.
- **Clear-on-match period.** Across several periods, a design that increments before clearing would show a period of GRk+2 ticks, and one that clears at the wrong time would show a period of GRk.
- **Capture edges.** A full sweep of every register, edge code and edge direction exposes a design that swaps rising and falling or captures with edge code 00.
- **Flag handshake.** The bench writes 0 without a prior read, writes 1 after a read, and clears while a match is held. A design that drops flags without the read, or lets the clear beat the set, shows a status bit that goes to zero.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd2;

    localparam int CTRL_UPDOWN = 0;
    localparam int CTRL_SEL    = 1;
    localparam int CTRL_CLREN  = 3;
    localparam int CTRL_REG0   = 4;
    localparam int CTRL_STRIDE = 3;

endpackage

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_in,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    import tmr_cc_pkg::*;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
        unique case (edge_e'(edge_sel))
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // R5: a detected edge lasts a single cycle
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/tmr_cc_greg.sv
module tmr_cc_greg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         cap_mode,
    input  logic         cap_hit,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         match,
    output logic         capture
);

    always_comb begin
        capture = cap_mode & cap_hit;
        match   = ~cap_mode & (value == cnt);
    end

    always_ff @(posedge clk) begin
        if (rst)
            value <= '1;
        else if (capture)
            value <= cnt;
        else if (wr)
            value <= wdata;
    end

    // R5: a capture stores the counter value of the capture cycle
    assert_capture_latch_R5: assert property (@(posedge clk) disable iff (rst)
        capture |=> value == $past(cnt));

    // R4: a compare register changes only by bus write
    assert_compare_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !wr) |=> $stable(value));

endmodule

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         updown,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr_match,
    input  logic         clr_cap,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         udf
);
    import tmr_cc_pkg::*;

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    dir_e         dir_q, dir_n, dir_eff;
    logic [W-1:0] cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_UP;
            cnt   <= '0;
        end else begin
            dir_q <= dir_n;
            cnt   <= cnt_n;
        end
    end

    // next state and outputs
    always_comb begin
        dir_eff = updown ? dir_q : DIR_UP;
        dir_n   = dir_eff;
        cnt_n   = cnt;
        ovf     = 1'b0;
        udf     = 1'b0;
        if (wr) begin
            cnt_n = wdata;
        end else if (clr_cap || (tick && clr_match)) begin
            cnt_n = '0;
            dir_n = DIR_UP;
        end else if (tick) begin
            unique case (dir_eff)
                DIR_UP: begin
                    if (cnt == MAXV) begin
                        ovf = 1'b1;
                        if (updown) begin
                            cnt_n = MAXV - ONE;
                            dir_n = DIR_DOWN;
                        end else begin
                            cnt_n = '0;
                        end
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (cnt == '0) begin
                        udf   = 1'b1;
                        cnt_n = ONE;
                        dir_n = DIR_UP;
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
                default: cnt_n = cnt;
            endcase
        end
    end

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (!updown && tick && !wr && !clr_cap && !clr_match && cnt != MAXV)
        |=> cnt == W'($past(cnt) + ONE));

    assert_turn_down_R3: assert property (@(posedge clk) disable iff (rst)
        (updown && tick && !wr && !clr_cap && !clr_match && dir_q == DIR_UP && cnt == MAXV)
        |=> (dir_q == DIR_DOWN && cnt == MAXV - ONE));

    assert_cap_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr && clr_cap) |=> (cnt == '0 && dir_q == DIR_UP));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr |=> cnt == $past(wdata));

endmodule

// File: rtl/tmr_cc_flags.sv
module tmr_cc_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         rd_stat,
    input  logic         wr_stat,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flags
);

    logic [N-1:0] armed;
    logic [N-1:0] clr;

    always_comb begin
        clr = wr_stat ? (~wdata & armed) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~clr) | set_ev;
            armed <= (armed & ~clr) | (rd_stat ? flags : '0);
        end
    end

    // R8: an event always leaves its flag set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (set_ev != '0) |=> ((flags & $past(set_ev)) == $past(set_ev)));

    // R7: a flag drops only after it was armed by a read
    assert_clear_armed_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flags) & ~flags & ~$past(armed)) == '0));

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
    parameter int W           = 16,
    parameter int NREG        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cnt_tick,
    input  logic [NREG-1:0]               cap_in,
    input  logic [tmr_cc_pkg::ADDR_W-1:0] bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [W-1:0]                  bus_wdata,
    output logic [W-1:0]                  bus_rdata
);
    import tmr_cc_pkg::*;

    localparam int SEL_W  = $clog2(NREG);
    localparam int NFLAG  = NREG + 2;

    logic [W-1:0]     ctrl_q;
    logic [W-1:0]     cnt;
    logic [W-1:0]     gr_val [NREG];
    logic [NREG-1:0]  match, capture, cap_hit, cap_mode, gr_wr;
    logic [NFLAG-1:0] flags;
    logic             ovf, udf, clr_en, clr_match, clr_cap;
    logic [SEL_W-1:0] clr_sel;
    logic             cnt_wr, ctrl_wr, stat_wr, stat_rd;

    always_comb begin
        cnt_wr  = bus_wr && bus_addr == ADR_CNT;
        ctrl_wr = bus_wr && bus_addr == ADR_CTRL;
        stat_wr = bus_wr && bus_addr == ADR_STAT;
        stat_rd = bus_rd && bus_addr == ADR_STAT;
        clr_en  = ctrl_q[CTRL_CLREN];
        clr_sel = ctrl_q[CTRL_SEL +: SEL_W];
        clr_match = clr_en & match[clr_sel];
        clr_cap   = clr_en & capture[clr_sel];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= bus_wdata;
    end

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            assign cap_mode[k] = ctrl_q[CTRL_REG0 + CTRL_STRIDE*k];
            assign gr_wr[k]    = bus_wr && bus_addr[ADDR_W-1] &&
                                 bus_addr[SEL_W-1:0] == SEL_W'(k);

            tmr_cc_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst      (rst),
                .async_in (cap_in[k]),
                .edge_sel (ctrl_q[CTRL_REG0 + CTRL_STRIDE*k + 1 +: 2]),
                .hit      (cap_hit[k])
            );

            tmr_cc_greg #(.W(W)) u_greg (
                .clk      (clk),
                .rst      (rst),
                .cnt      (cnt),
                .cap_mode (cap_mode[k]),
                .cap_hit  (cap_hit[k]),
                .wr       (gr_wr[k]),
                .wdata    (bus_wdata),
                .value    (gr_val[k]),
                .match    (match[k]),
                .capture  (capture[k])
            );
        end
    endgenerate

    tmr_cc_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (cnt_tick),
        .updown    (ctrl_q[CTRL_UPDOWN]),
        .wr        (cnt_wr),
        .wdata     (bus_wdata),
        .clr_match (clr_match),
        .clr_cap   (clr_cap),
        .cnt       (cnt),
        .ovf       (ovf),
        .udf       (udf)
    );

    tmr_cc_flags #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_ev  ({udf, ovf, match | capture}),
        .rd_stat (stat_rd),
        .wr_stat (stat_wr),
        .wdata   (bus_wdata[NFLAG-1:0]),
        .flags   (flags)
    );

    always_comb begin
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata = gr_val[bus_addr[SEL_W-1:0]];
        end else begin
            unique case (bus_addr)
                ADR_CNT:  bus_rdata = cnt;
                ADR_CTRL: bus_rdata = ctrl_q;
                ADR_STAT: bus_rdata = W'(flags);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R10: a general register write reads back whole
    assert_gr_write_R10: assert property (@(posedge clk) disable iff (rst)
        (gr_wr[0] && !capture[0]) |=> gr_val[0] == $past(bus_wdata));

endmodule

// File: tb/tmr_cc_channel_test.sv
`timescale 1ns/1ps
module tmr_cc_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_tick = 1'b0;
    logic [3:0]  cap_in = 4'h0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    tmr_cc_channel uut (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        rd(3'd2, d);
        wr(3'd2, 16'h0000);
    endtask

    initial begin
        #800000;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [15:0] d, exp_gr;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); check("R1 cnt", d, 16'h0000);
        rd(3'd1, d); check("R1 ctrl", d, 16'h0000);
        rd(3'd2, d); check("R1 status", d, 16'h0000);
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), d); check("R1 gr", d, 16'hFFFF);
        end

        // R10 whole-word access
        for (int k = 0; k < 4; k++) begin
            wr(3'(4 + k), 16'hA5C3 ^ 16'(k * 16'h1111));
            rd(3'(4 + k), d); check("R10 gr", d, 16'hA5C3 ^ 16'(k * 16'h1111));
        end
        wr(3'd0, 16'h1234); rd(3'd0, d); check("R10 cnt", d, 16'h1234);
        for (int k = 0; k < 4; k++) wr(3'(4 + k), 16'hF000);

        // R2 increment sweep
        foreach (d[i]) begin end
        for (int vi = 0; vi < 4; vi++) begin
            logic [15:0] v;
            v = (vi == 0) ? 16'h0000 : (vi == 1) ? 16'h00FF : (vi == 2) ? 16'h1234 : 16'h7FFE;
            for (int n = 1; n <= 5; n++) begin
                wr(3'd0, v); ticks(n); rd(3'd0, d);
                check("R2 step", d, v + 16'(n));
            end
        end

        // R2 wrap and overflow, R7 handshake
        clear_flags();
        wr(3'd0, 16'hFFFE); ticks(3); rd(3'd0, d); check("R2 wrap", d, 16'h0001);
        rd(3'd2, d); check("R2 ovf", d & 16'h0030, 16'h0010);
        clear_flags();
        wr(3'd0, 16'hFFFE); ticks(3);
        wr(3'd2, 16'h0000); rd(3'd2, d); check("R7 no read no clear", d & 16'h0010, 16'h0010);
        wr(3'd2, 16'h0010); rd(3'd2, d); check("R7 write one keeps", d & 16'h0010, 16'h0010);
        wr(3'd2, 16'h0000); rd(3'd2, d); check("R7 read then clear", d & 16'h0010, 16'h0000);

        // R3 up/down turn-around
        wr(3'd1, 16'h0001);
        clear_flags();
        wr(3'd0, 16'hFFFD); ticks(2); rd(3'd0, d); check("R3 up top", d, 16'hFFFF);
        ticks(1); rd(3'd0, d); check("R3 turn down", d, 16'hFFFE);
        rd(3'd2, d); check("R3 ovf", d & 16'h0030, 16'h0010);
        ticks(1); rd(3'd0, d); check("R3 down", d, 16'hFFFD);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0002); ticks(2); rd(3'd0, d); check("R3 bottom", d, 16'h0000);
        ticks(1); rd(3'd0, d); check("R3 turn up", d, 16'h0001);
        rd(3'd2, d); check("R3 udf", d & 16'h0030, 16'h0020);
        ticks(1); rd(3'd0, d); check("R3 up again", d, 16'h0002);
        wr(3'd1, 16'h0000);

        // R4 no match when unequal
        clear_flags();
        wr(3'd0, 16'h0010); rd(3'd2, d); check("R4 no match", d & 16'h000F, 16'h0000);

        // R4 / R6 clear-on-match period sweep
        for (int pi = 0; pi < 4; pi++) begin
            int n, k, m;
            n = (pi == 0) ? 3 : (pi == 1) ? 5 : (pi == 2) ? 8 : 13;
            k = n % 4;
            m = 2 * n + 3;
            wr(3'd1, 16'h0008 | 16'(k << 1));
            wr(3'(4 + k), 16'(n));
            wr(3'd0, 16'h0000);
            clear_flags();
            ticks(m); rd(3'd0, d); check("R6 period", d, 16'(m % (n + 1)));
            rd(3'd2, d); check("R4 match flag", (d >> k) & 16'h1, 16'h0001);
            wr(3'(4 + k), 16'hF000);
        end
        wr(3'd1, 16'h0000);

        // R5 capture sweep: every register, edge code, direction
        for (int k = 0; k < 4; k++) begin
            for (int md = 0; md < 4; md++) begin
                wr(3'd1, 16'(1 << (4 + 3 * k)) | 16'(md << (5 + 3 * k)));
                wr(3'(4 + k), 16'hFFFF);
                exp_gr = 16'hFFFF;
                wr(3'd0, 16'h0100 + 16'(k * 16 + md));
                clear_flags();
                @(negedge clk); cap_in[k] = 1'b1;
                repeat (5) @(negedge clk);
                if (md[0]) exp_gr = 16'h0100 + 16'(k * 16 + md);
                rd(3'(4 + k), d); check("R5 rise value", d, exp_gr);
                rd(3'd2, d); check("R5 rise flag", (d >> k) & 16'h1, 16'(md & 1));
                wr(3'd0, 16'h0200 + 16'(k * 16 + md));
                clear_flags();
                @(negedge clk); cap_in[k] = 1'b0;
                repeat (5) @(negedge clk);
                if (md[1]) exp_gr = 16'h0200 + 16'(k * 16 + md);
                rd(3'(4 + k), d); check("R5 fall value", d, exp_gr);
                rd(3'd2, d); check("R5 fall flag", (d >> k) & 16'h1, 16'((md >> 1) & 1));
            end
        end

        // R6 capture clears counter
        wr(3'd1, 16'h0400 | 16'h0800 | 16'h0008 | 16'h0004);
        wr(3'd0, 16'h0500);
        @(negedge clk); cap_in[2] = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd0, d); check("R6 capture clear cnt", d, 16'h0000);
        rd(3'd6, d); check("R6 capture value", d, 16'h0500);
        cap_in[2] = 1'b0;
        repeat (5) @(negedge clk);

        // R8 set beats clear
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0077); wr(3'd4, 16'h0077);
        rd(3'd2, d); check("R8 flag before", d & 16'h0001, 16'h0001);
        wr(3'd2, 16'h0000);
        rd(3'd2, d); check("R8 set wins", d & 16'h0001, 16'h0001);
        wr(3'd4, 16'hF000);

        // R9 bus write beats counting and clear-on-match
        wr(3'd0, 16'h0010);
        @(negedge clk);
        cnt_tick = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0040; bus_wr = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0; bus_wr = 1'b0;
        rd(3'd0, d); check("R9 write beats tick", d, 16'h0040);
        wr(3'd1, 16'h0008);
        wr(3'd4, 16'h0010);
        wr(3'd0, 16'h0010);
        @(negedge clk);
        cnt_tick = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0041; bus_wr = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0; bus_wr = 1'b0;
        rd(3'd0, d); check("R9 write beats clear", d, 16'h0041);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule